// File: doc/BRIEF.md
# Maintenance Window Address Translator

This block sits on a local single-master bus and turns accesses that fall inside a 4 MiB maintenance window into remote configuration requests. A 32-bit target register is programmed first. It names the remote device by destination ID and by hop count, and it supplies the upper configuration offset bits.

Each later read or write inside the window becomes one request on a valid/ready channel. The request carries:
- the destination and the hop count,
- a word-aligned configuration offset,
- big-endian byte-lane enables,
- the lane-placed write data.

The block then waits for a single response. Read data comes back from the big-endian lanes right-justified onto the bus. If no response arrives within a programmable number of cycles, the access ends with an error.

Accesses outside the window are not touched and raise no request. The 4 KiB region directly after the window is flagged separately, as the outbound doorbell area, for a neighbouring block. The window position is given as the address bits above the window size. The timeout is a cycle count on an input.

Top module: `maint_xlate`

## Requirements
- R1: After reset the block drives no request and no bus completion, and the target register reads as zero.
- R2: A bus access whose address equals `TGT_ADDR` reads or writes the whole 32-bit target register, whatever the size code, and completes on the bus one cycle after it is accepted.
- R3: An access with `bus_addr[31:22] == win_page` raises exactly one request. Any access that hits neither the window, the doorbell area nor the target register asserts `pt_sel`, raises no request and gets no `bus_done`.
- R4: An access in the 4 KiB immediately above the window's end asserts `db_sel`, and not `pt_sel`, and raises no request.
- R5: Each request carries:
  - destination = target bits [29:22],
  - hop count = target bits [19:12],
  - offset = {target bits [1:0], `bus_addr[21:2]`, 2'b00}.
- R6: Size code 0 is one byte, 1 is two bytes and 2 is four bytes. The byte at address low bits `a` occupies lane bits [31-8a -: 8]; enable bit 3-a marks it. A two-byte access uses `bus_addr[1]` to pick the upper (0) or lower (1) half, with its high byte at the lower address. Write data is taken from the low bits of `bus_wdata` and placed in that lane or half.
- R7: Read data is taken from the selected lane or half, right-justified and zero-extended onto `bus_rdata`.
- R8: Size code 3 behaves exactly like size code 2. A four-byte access ignores `bus_addr[1:0]` and enables all four lanes.
- R9: The request holds steady until `mreq_ready`. Only one request is outstanding at a time. `bus_done` is a single-cycle pulse, and no other access, including a target register write, is taken until the outstanding response or timeout.
- R10: A response is accepted in any of the first `tmo_limit` cycles after the request handshake. With none in that time the access ends with `bus_err` set and, for reads, `bus_rdata` all ones.
- R11: A response arriving while no request awaits one is ignored and does not affect the next access.
- R12: A response carrying `mrsp_err` ends the access with `bus_err` set and read data all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| win_page | input | 10 | Address bits [31:22] of the maintenance window |
| tmo_limit | input | 16 | Response timeout in cycles |
| bus_valid | input | 1 | Bus access valid, held until `bus_done` |
| bus_write | input | 1 | 1 for write |
| bus_addr | input | 32 | Byte address |
| bus_size | input | 2 | 0: 1 byte, 1: 2 bytes, 2 or 3: 4 bytes |
| bus_wdata | input | 32 | Write data, right-justified |
| bus_done | output | 1 | Completion pulse for window and target register accesses |
| bus_rdata | output | 32 | Read data, valid with `bus_done` |
| bus_err | output | 1 | Access ended in error, valid with `bus_done` |
| pt_sel | output | 1 | Access is outside this block and passes through |
| db_sel | output | 1 | Access hits the doorbell area after the window |
| mreq_valid | output | 1 | Request valid |
| mreq_ready | input | 1 | Request accepted |
| mreq_write | output | 1 | Request is a write |
| mreq_dest | output | 8 | Destination ID |
| mreq_hop | output | 8 | Hop count |
| mreq_off | output | 24 | Word-aligned configuration offset |
| mreq_be | output | 4 | Big-endian lane enables, bit 3 = lowest address |
| mreq_wdata | output | 32 | Lane-placed write data |
| mrsp_valid | input | 1 | Response valid |
| mrsp_data | input | 32 | Response data in big-endian lanes |
| mrsp_err | input | 1 | Response reports an error |

## Verification
The hardest behaviour to bring about from the ports is the window around the timeout. One case is a response arriving exactly in the last accepted cycle. The other is a response arriving after the timeout, while the block is idle, which must be ignored. The bench's remote responder takes a per-access response delay. Directed accesses place the reply at `tmo_limit`-1 cycles, at `tmo_limit` cycles, and well past it, and a normal read follows the late one to show nothing leaked. Random accesses mix sizes, lane positions, target register rewrites, ready back-pressure and injected error responses.

// File: rtl/maint_xlate.sv
module maint_xlate #(
  parameter int AW       = 32,
  parameter int WIN_W    = 22,
  parameter int DB_W     = 12,
  parameter int OFS_W    = 24,
  parameter int DEST_W   = 8,
  parameter int HOP_W    = 8,
  parameter int TMO_W    = 16,
  parameter logic [AW-1:0] TGT_ADDR = 32'hFFFF_0000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [AW-WIN_W-1:0]  win_page,
  input  logic [TMO_W-1:0]     tmo_limit,
  input  logic                 bus_valid,
  input  logic                 bus_write,
  input  logic [AW-1:0]        bus_addr,
  input  logic [1:0]           bus_size,
  input  logic [31:0]          bus_wdata,
  output logic                 bus_done,
  output logic [31:0]          bus_rdata,
  output logic                 bus_err,
  output logic                 pt_sel,
  output logic                 db_sel,
  output logic                 mreq_valid,
  input  logic                 mreq_ready,
  output logic                 mreq_write,
  output logic [DEST_W-1:0]    mreq_dest,
  output logic [HOP_W-1:0]     mreq_hop,
  output logic [OFS_W-1:0]     mreq_off,
  output logic [3:0]           mreq_be,
  output logic [31:0]          mreq_wdata,
  input  logic                 mrsp_valid,
  input  logic [31:0]          mrsp_data,
  input  logic                 mrsp_err
);
  localparam int EXT_W = OFS_W - WIN_W;
  localparam int DEST_LSB = 22;
  localparam int HOP_LSB = 12;
  localparam logic [AW-DB_W-1:0] DB_STEP = (AW-DB_W)'(1) << (WIN_W - DB_W);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_DONE} state_t;

  state_t            state;
  logic [31:0]       tgt;
  logic [TMO_W-1:0]  cnt;
  logic [TMO_W:0]    cnt_nx;
  logic [1:0]        sz_q, a_q;
  logic [31:0]       rdata_q;
  logic              err_q;
  logic              win_hit, db_hit, tgt_hit;
  logic [AW-DB_W-1:0] db_page;

  function automatic logic [3:0] lane_be(input logic [1:0] sz, input logic [1:0] a);
    if (sz[1]) return 4'b1111;
    if (sz[0]) return a[1] ? 4'b0011 : 4'b1100;
    case (a)
      2'd0: return 4'b1000;
      2'd1: return 4'b0100;
      2'd2: return 4'b0010;
      default: return 4'b0001;
    endcase
  endfunction

  function automatic logic [31:0] lane_put(input logic [1:0] sz, input logic [1:0] a,
                                           input logic [31:0] w);
    if (sz[1]) return w;
    if (sz[0]) return a[1] ? {16'h0, w[15:0]} : {w[15:0], 16'h0};
    case (a)
      2'd0: return {w[7:0], 24'h0};
      2'd1: return {8'h0, w[7:0], 16'h0};
      2'd2: return {16'h0, w[7:0], 8'h0};
      default: return {24'h0, w[7:0]};
    endcase
  endfunction

  function automatic logic [31:0] lane_get(input logic [1:0] sz, input logic [1:0] a,
                                           input logic [31:0] d);
    if (sz[1]) return d;
    if (sz[0]) return a[1] ? {16'h0, d[15:0]} : {16'h0, d[31:16]};
    case (a)
      2'd0: return {24'h0, d[31:24]};
      2'd1: return {24'h0, d[23:16]};
      2'd2: return {24'h0, d[15:8]};
      default: return {24'h0, d[7:0]};
    endcase
  endfunction

  assign db_page = {win_page, {(WIN_W-DB_W){1'b0}}} + DB_STEP;
  assign tgt_hit = bus_addr == TGT_ADDR;
  assign win_hit = !tgt_hit && bus_addr[AW-1:WIN_W] == win_page;
  assign db_hit  = !tgt_hit && bus_addr[AW-1:DB_W] == db_page;

  assign pt_sel     = bus_valid && !tgt_hit && !win_hit && !db_hit;
  assign db_sel     = bus_valid && db_hit;
  assign mreq_valid = state == S_ISSUE;
  assign bus_done   = state == S_DONE;
  assign bus_rdata  = rdata_q;
  assign bus_err    = err_q;
  assign cnt_nx     = {1'b0, cnt} + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      tgt        <= '0;
      cnt        <= '0;
      sz_q       <= '0;
      a_q        <= '0;
      rdata_q    <= '0;
      err_q      <= 1'b0;
      mreq_write <= 1'b0;
      mreq_dest  <= '0;
      mreq_hop   <= '0;
      mreq_off   <= '0;
      mreq_be    <= '0;
      mreq_wdata <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (bus_valid && tgt_hit) begin
            rdata_q <= tgt;
            err_q   <= 1'b0;
            if (bus_write) tgt <= bus_wdata;
            state   <= S_DONE;
          end else if (bus_valid && win_hit) begin
            sz_q       <= bus_size;
            a_q        <= bus_addr[1:0];
            mreq_write <= bus_write;
            mreq_dest  <= tgt[DEST_LSB +: DEST_W];
            mreq_hop   <= tgt[HOP_LSB +: HOP_W];
            mreq_off   <= {tgt[EXT_W-1:0], bus_addr[WIN_W-1:2], 2'b00};
            mreq_be    <= lane_be(bus_size, bus_addr[1:0]);
            mreq_wdata <= lane_put(bus_size, bus_addr[1:0], bus_wdata);
            state      <= S_ISSUE;
          end
        end
        S_ISSUE: begin
          if (mreq_ready) begin
            cnt   <= '0;
            state <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (mrsp_valid) begin
            rdata_q <= mrsp_err ? '1 : lane_get(sz_q, a_q, mrsp_data);
            err_q   <= mrsp_err;
            state   <= S_DONE;
          end else if (cnt_nx >= {1'b0, tmo_limit}) begin
            rdata_q <= '1;
            err_q   <= 1'b1;
            state   <= S_DONE;
          end else begin
            cnt <= cnt_nx[TMO_W-1:0];
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/maint_xlate_chk.sv
module maint_xlate_chk #(
  parameter int DEST_W = 8,
  parameter int OFS_W  = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic              bus_done,
  input logic [31:0]       bus_rdata,
  input logic              bus_err,
  input logic              pt_sel,
  input logic              db_sel,
  input logic              mreq_valid,
  input logic              mreq_ready,
  input logic [DEST_W-1:0] mreq_dest,
  input logic [OFS_W-1:0]  mreq_off,
  input logic [3:0]        mreq_be,
  input logic [31:0]       mreq_wdata
);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid && !mreq_ready |=> mreq_valid && $stable(mreq_off) && $stable(mreq_be)
      && $stable(mreq_wdata) && $stable(mreq_dest));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_done |=> !bus_done);

  p_pt_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pt_sel |-> !mreq_valid && !bus_done);

  p_req_bus_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid |-> bus_valid);

  p_sel_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pt_sel, db_sel, mreq_valid}));

  p_be_shape_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid |-> ($countones(mreq_be) == 1 || $countones(mreq_be) == 2 || mreq_be == 4'b1111));

  p_err_ones_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_done && bus_err && !bus_write |-> bus_rdata == 32'hFFFF_FFFF);
endmodule

bind maint_xlate maint_xlate_chk #(.DEST_W(DEST_W), .OFS_W(OFS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_done(bus_done), .bus_rdata(bus_rdata), .bus_err(bus_err),
  .pt_sel(pt_sel), .db_sel(db_sel), .mreq_valid(mreq_valid), .mreq_ready(mreq_ready),
  .mreq_dest(mreq_dest), .mreq_off(mreq_off), .mreq_be(mreq_be), .mreq_wdata(mreq_wdata)
);

// File: tb/tb_maint_xlate.sv
module tb_maint_xlate;
  localparam logic [31:0] TGT = 32'hFFFF_0000;
  localparam logic [31:0] BASE = 32'h1040_0000;
  localparam int LIMIT = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  win_page = BASE[31:22];
  logic [15:0] tmo_limit = 16'(LIMIT);
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [31:0] bus_addr = '0, bus_wdata = '0;
  logic [1:0]  bus_size = '0;
  logic        bus_done, bus_err, pt_sel, db_sel;
  logic [31:0] bus_rdata;
  logic        mreq_valid, mreq_write;
  logic        mreq_ready = 1'b0;
  logic [7:0]  mreq_dest, mreq_hop;
  logic [23:0] mreq_off;
  logic [3:0]  mreq_be;
  logic [31:0] mreq_wdata;
  logic        mrsp_valid = 1'b0, mrsp_err = 1'b0;
  logic [31:0] mrsp_data = '0;

  always #2.5 clk = ~clk;

  maint_xlate dut (
    .clk(clk), .rst_n(rst_n), .win_page(win_page), .tmo_limit(tmo_limit),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_wdata(bus_wdata), .bus_done(bus_done), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .pt_sel(pt_sel), .db_sel(db_sel), .mreq_valid(mreq_valid), .mreq_ready(mreq_ready),
    .mreq_write(mreq_write), .mreq_dest(mreq_dest), .mreq_hop(mreq_hop), .mreq_off(mreq_off),
    .mreq_be(mreq_be), .mreq_wdata(mreq_wdata), .mrsp_valid(mrsp_valid),
    .mrsp_data(mrsp_data), .mrsp_err(mrsp_err)
  );

  int vectors = 0, miscompares = 0;
  int nreq = 0;
  int resp_delay = 0;
  logic resp_err_inj = 1'b0;
  logic resp_busy = 1'b0;
  logic [31:0] t_tgt = '0;
  logic        cap_write;
  logic [7:0]  cap_dest, cap_hop;
  logic [23:0] cap_off;
  logic [3:0]  cap_be;
  logic [31:0] cap_wdata;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [7:0] d, input logic [7:0] h, input logic [23:0] o);
    return {d, h, o[15:0]} ^ 32'h5A3C_0F96;
  endfunction

  function automatic logic [3:0] f_be(input logic [1:0] sz, input logic [1:0] a);
    if (sz >= 2) return 4'hF;
    if (sz == 1) return a[1] ? 4'b0011 : 4'b1100;
    return 4'b1000 >> a;
  endfunction

  function automatic logic [31:0] f_put(input logic [1:0] sz, input logic [1:0] a, input logic [31:0] w);
    if (sz >= 2) return w;
    if (sz == 1) return a[1] ? {16'h0, w[15:0]} : {w[15:0], 16'h0};
    return {24'h0, w[7:0]} << (8 * (3 - int'(a)));
  endfunction

  function automatic logic [31:0] f_get(input logic [1:0] sz, input logic [1:0] a, input logic [31:0] d);
    if (sz >= 2) return d;
    if (sz == 1) return a[1] ? {16'h0, d[15:0]} : {16'h0, d[31:16]};
    return (d >> (8 * (3 - int'(a)))) & 32'hFF;
  endfunction

  initial begin
    forever begin
      @(negedge clk);
      if (mreq_valid) begin
        resp_busy = 1'b1;
        repeat ($urandom % 3) @(negedge clk);
        cap_write = mreq_write; cap_dest = mreq_dest; cap_hop = mreq_hop;
        cap_off = mreq_off; cap_be = mreq_be; cap_wdata = mreq_wdata;
        nreq++;
        mreq_ready = 1'b1;
        @(negedge clk);
        mreq_ready = 1'b0;
        repeat (resp_delay) @(negedge clk);
        mrsp_valid = 1'b1;
        mrsp_err = resp_err_inj;
        mrsp_data = model(cap_dest, cap_hop, cap_off);
        @(negedge clk);
        mrsp_valid = 1'b0;
        mrsp_err = 1'b0;
        resp_busy = 1'b0;
      end
    end
  end

  task automatic do_acc(input logic w, input logic [31:0] addr, input logic [1:0] sz,
                        input logic [31:0] wd, output logic [31:0] rd, output logic err);
    bit got = 0;
    @(negedge clk);
    bus_valid = 1'b1; bus_write = w; bus_addr = addr; bus_size = sz; bus_wdata = wd;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (bus_done) begin
        rd = bus_rdata; err = bus_err; got = 1;
        break;
      end
    end
    bus_valid = 1'b0;
    if (!got) begin
      rd = 'x; err = 1'bx;
      chk("R9 access never completed", 32'd0, 32'd1);
    end
  endtask

  task automatic tgt_write(input logic [31:0] v, input logic [1:0] sz);
    logic [31:0] rd; logic err;
    do_acc(1'b1, TGT, sz, v, rd, err);
    t_tgt = v;
  endtask

  task automatic tgt_read(input string tag);
    logic [31:0] rd; logic err;
    do_acc(1'b0, TGT, 2'd0, 32'h0, rd, err);
    chk(tag, rd, t_tgt);
  endtask

  task automatic win_acc(input logic w, input logic [21:0] woff, input logic [1:0] sz,
                         input logic [31:0] wd, input int dly, input logic rerr, input string tag);
    logic [31:0] rd; logic err; int n0;
    logic [31:0] addr; logic [23:0] eoff; logic bad;
    addr = BASE | {10'h0, woff};
    eoff = {t_tgt[1:0], woff[21:2], 2'b00};
    bad = rerr || (dly >= LIMIT);
    resp_delay = dly; resp_err_inj = rerr;
    n0 = nreq;
    do_acc(w, addr, sz, wd, rd, err);
    while (resp_busy) @(negedge clk);
    repeat (2) @(negedge clk);
    chk({tag, " R3 one request"}, 32'(nreq - n0), 32'd1);
    chk({tag, " R5 dest"}, {24'h0, cap_dest}, {24'h0, t_tgt[29:22]});
    chk({tag, " R5 hop"}, {24'h0, cap_hop}, {24'h0, t_tgt[19:12]});
    chk({tag, " R5 offset"}, {8'h0, cap_off}, {8'h0, eoff});
    chk({tag, " R6 lane enables"}, {28'h0, cap_be}, {28'h0, f_be(sz, woff[1:0])});
    chk({tag, " R6 direction"}, {31'h0, cap_write}, {31'h0, w});
    if (w) chk({tag, " R6 write lanes"}, cap_wdata, f_put(sz, woff[1:0], wd));
    chk({tag, " R10 R12 error flag"}, {31'h0, err}, {31'h0, bad});
    if (!w) chk({tag, " R7 R10 R12 read data"}, rd,
                bad ? 32'hFFFF_FFFF : f_get(sz, woff[1:0], model(t_tgt[29:22], t_tgt[19:12], eoff)));
  endtask

  task automatic outside(input logic [31:0] addr, input logic exp_db, input string tag);
    int n0; bit quiet = 1;
    n0 = nreq;
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = addr; bus_size = 2'd2;
    @(negedge clk);
    chk({tag, " R3 pt_sel"}, {31'h0, pt_sel}, {31'h0, !exp_db});
    chk({tag, " R4 db_sel"}, {31'h0, db_sel}, {31'h0, exp_db});
    repeat (6) begin
      @(negedge clk);
      if (mreq_valid || bus_done) quiet = 0;
    end
    bus_valid = 1'b0;
    chk({tag, " R3 R4 no request or completion"}, {31'h0, quiet}, 32'd1);
    chk({tag, " R3 R4 request count"}, 32'(nreq - n0), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 bus_done in reset", {31'h0, bus_done}, 32'd0);
    chk("R1 mreq_valid in reset", {31'h0, mreq_valid}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 no request after reset", {31'h0, mreq_valid}, 32'd0);
    tgt_read("R1 target register reset value");

    tgt_write(32'hABC5_5003, 2'd0);
    tgt_read("R2 full word written with byte size code");
    tgt_write(32'h2D4F_F001, 2'd1);
    tgt_read("R2 target register readback");

    win_acc(1'b0, 22'h000000, 2'd2, 0, 0, 1'b0, "R7 first word");
    win_acc(1'b0, 22'h3FFFFF, 2'd0, 0, 1, 1'b0, "R7 last byte");
    for (int a = 0; a < 4; a++) begin
      win_acc(1'b1, 22'h001230 | 22'(a), 2'd0, 32'h0000_00C3 + a, 2, 1'b0, "R6 byte write");
      win_acc(1'b0, 22'h004560 | 22'(a), 2'd0, 0, 1, 1'b0, "R7 byte read");
    end
    win_acc(1'b1, 22'h000102, 2'd1, 32'h0000_BEEF, 0, 1'b0, "R6 low half write");
    win_acc(1'b1, 22'h000100, 2'd1, 32'h0000_CAFE, 0, 1'b0, "R6 high half write");
    win_acc(1'b0, 22'h000202, 2'd1, 0, 0, 1'b0, "R7 low half read");
    win_acc(1'b0, 22'h000200, 2'd1, 0, 0, 1'b0, "R7 high half read");
    win_acc(1'b1, 22'h000307, 2'd3, 32'h1234_5678, 0, 1'b0, "R8 size3 write");
    win_acc(1'b0, 22'h000305, 2'd3, 0, 0, 1'b0, "R8 size3 read");

    win_acc(1'b0, 22'h010000, 2'd2, 0, LIMIT - 1, 1'b0, "R10 last accepted cycle");
    win_acc(1'b0, 22'h010004, 2'd2, 0, LIMIT, 1'b0, "R10 first timed-out cycle");
    win_acc(1'b1, 22'h010008, 2'd2, 32'h5555_AAAA, LIMIT + 2, 1'b0, "R10 write timeout");
    win_acc(1'b0, 22'h01000C, 2'd2, 0, LIMIT + 3, 1'b0, "R11 late response");
    win_acc(1'b0, 22'h020010, 2'd1, 0, 3, 1'b0, "R11 read after late response");
    win_acc(1'b0, 22'h030000, 2'd0, 0, 2, 1'b1, "R12 error response read");
    win_acc(1'b1, 22'h030004, 2'd2, 32'h1, 2, 1'b1, "R12 error response write");

    outside(BASE - 1, 1'b0, "below window");
    outside(BASE + 32'h0040_1000, 1'b0, "above doorbell area");
    outside(BASE + 32'h0040_0000, 1'b1, "doorbell first byte");
    outside(BASE + 32'h0040_0FFF, 1'b1, "doorbell last byte");

    for (int i = 0; i < 250; i++) begin
      if (i % 10 == 0) begin
        tgt_write($urandom, 2'($urandom % 4));
        if (i % 30 == 0) tgt_read("R2 random readback");
      end
      win_acc(1'($urandom % 2), 22'($urandom), 2'($urandom % 4), $urandom,
              int'($urandom % LIMIT), ($urandom % 16) == 0, "R5 R6 R7 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule